// File: doc/BRIEF.md
# Ternary Rule Table with Indirect Access Engine

This block holds a table of ternary rules, each made of a data vector and a mask vector, and compares a lookup key against every rule at once. The lookup returns whether any rule matched and the index of the lowest-numbered matching rule. A rule takes part in matching only while one of the two lowest bits of its first data word (its valid bits) is set.

Software never touches the table directly. It fills a bank of staging words (data words at bus addresses 0 to WORDS-1, mask words at WORDS to 2*WORDS-1), then writes one control word at bus address 2*WORDS. That word selects the operation, the target storage and the entry address, and starts the operation with a start bit that the hardware clears when it is finished. Besides single-entry reads and writes, the engine can walk the table looking for valid rules, stopping at each one so software can collect it, and it can wipe the entire table. Operations aimed at the two companion storages, the action storage and the meter storage, are not carried out here; they only produce a one-cycle request strobe.

Top module: `tcam_table`

## Requirements
- R1: After reset the control word reads 0, every staging word reads 0 and no key produces a hit.
- R2: A bus write to a staging word (data word w at address w, mask word w at address WORDS+w) is read back unchanged at that address.
- R3: The control word has start at bit 0, a one-hot operation code at bits 3:1 (1 read, 2 write, 4 search), a storage select at bits 14:10 (1 rule table, 2 action, 4 meter), table wipe at bit 15, entry address from bit 16 and search hit flag at bit 27. A write operation on the rule table copies the staging words into the addressed entry; start reads 1 in the cycle after the control write and 0 in the cycle after that.
- R4: A read operation on the rule table loads the staging data and mask words from the addressed entry, with the same one-cycle completion as R3.
- R5: A rule matches a key when its valid bits are not both zero and (key AND mask) equals (data AND mask), taken over the whole key width.
- R6: When several rules match, hit_idx reports the lowest index among them.
- R7: A rule whose valid bits are both zero never matches; reading it, clearing bits 1:0 of data word 0 in staging and writing it back removes it from lookups.
- R8: A search starts at the address written into the control word and steps one entry per cycle; at the first valid entry it stops with bit 27 set, the address field holding that entry index and the staging words holding that entry.
- R9: A stopped search stays at its entry until software reads data word WORDS-1, then continues at the next entry; after the last entry it clears start with bit 27 clear.
- R10: Setting bit 15 clears every entry, one per cycle; bit 15 reads 1 until all ENTRIES entries are cleared and then 0, after which no key hits.
- R11: A control write made while an operation or a wipe is in progress is ignored.
- R12: Starting any operation with storage select 2 or 4 leaves the rule table untouched, raises ext_ram_go bit 0 (select 2) or bit 1 (select 4) for exactly one cycle and then clears start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (used to resume a stopped search) |
| bus_addr | input | BA_W | Register address: staging data, staging mask, control |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| key | input | KEY_W | Lookup key |
| hit | output | 1 | Some valid rule matches key |
| hit_idx | output | AW | Lowest matching rule index |
| ext_ram_go | output | 2 | One-cycle request: bit 0 action storage, bit 1 meter storage |

## Verification
The bench builds the block with ENTRIES set to 16 and WORDS left at 8, so the full 256-bit key and staging width stay in play while a search can run off the end of the table and a wipe can finish within a few dozen cycles. That brings the last-entry completion of a search, the full wipe count and the priority between overlapping rules into short directed tests, alongside the exact cycle on which start clears.

// File: rtl/tcam_table.sv
module tcam_table #(
  parameter int ENTRIES = 256,
  parameter int WORDS   = 8,
  parameter int AW      = $clog2(ENTRIES),
  parameter int KEY_W   = 32 * WORDS,
  parameter int BA_W    = $clog2(2 * WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [BA_W-1:0]  bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [AW-1:0]    hit_idx,
  output logic [1:0]       ext_ram_go
);
  localparam int CTRL_A = 2 * WORDS;
  localparam int LAST   = ENTRIES - 1;

  logic [KEY_W-1:0] mem_d [ENTRIES];
  logic [KEY_W-1:0] mem_m [ENTRIES];
  logic [KEY_W-1:0] stage_d, stage_m;
  logic             start_q, clr_q, found_q;
  logic [2:0]       op_q;
  logic [4:0]       ram_q;
  logic [AW-1:0]    addr_q;
  logic [ENTRIES-1:0] hv;
  logic [31:0]      ctrl_v;

  wire ctrl_sel = int'(bus_addr) == CTRL_A;
  wire on_tcam  = ram_q == 5'd1;
  wire is_rd    = op_q == 3'd1;
  wire is_wr    = op_q == 3'd2;
  wire is_sr    = op_q == 3'd4;
  wire at_last  = int'(addr_q) == LAST;
  wire resume   = found_q && bus_re && int'(bus_addr) == WORDS - 1;
  wire cur_ok   = |mem_d[addr_q][1:0];

  assign ext_ram_go = {start_q && ram_q == 5'd4, start_q && ram_q == 5'd2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      clr_q   <= 1'b0;
      found_q <= 1'b0;
      op_q    <= '0;
      ram_q   <= '0;
      addr_q  <= '0;
      stage_d <= '0;
      stage_m <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        mem_d[i] <= '0;
        mem_m[i] <= '0;
      end
    end else begin
      if (bus_we && int'(bus_addr) < WORDS)
        stage_d[int'(bus_addr)*32 +: 32] <= bus_wdata;
      else if (bus_we && int'(bus_addr) < CTRL_A)
        stage_m[(int'(bus_addr) - WORDS)*32 +: 32] <= bus_wdata;

      if (clr_q) begin
        mem_d[addr_q] <= '0;
        mem_m[addr_q] <= '0;
        if (at_last) clr_q <= 1'b0;
        else addr_q <= addr_q + 1'b1;
      end else if (start_q) begin
        if (!on_tcam || !(is_rd || is_wr || is_sr)) begin
          start_q <= 1'b0;
        end else if (is_rd) begin
          stage_d <= mem_d[addr_q];
          stage_m <= mem_m[addr_q];
          start_q <= 1'b0;
        end else if (is_wr) begin
          mem_d[addr_q] <= stage_d;
          mem_m[addr_q] <= stage_m;
          start_q <= 1'b0;
        end else if (found_q) begin
          if (resume) begin
            found_q <= 1'b0;
            if (at_last) start_q <= 1'b0;
            else addr_q <= addr_q + 1'b1;
          end
        end else if (cur_ok) begin
          found_q <= 1'b1;
          stage_d <= mem_d[addr_q];
          stage_m <= mem_m[addr_q];
        end else if (at_last) begin
          start_q <= 1'b0;
        end else begin
          addr_q <= addr_q + 1'b1;
        end
      end else if (bus_we && ctrl_sel) begin
        op_q    <= bus_wdata[3:1];
        ram_q   <= bus_wdata[14:10];
        found_q <= 1'b0;
        if (bus_wdata[15]) begin
          clr_q  <= 1'b1;
          addr_q <= '0;
        end else begin
          start_q <= bus_wdata[0];
          addr_q  <= bus_wdata[16 +: AW];
        end
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hv[i] = (|mem_d[i][1:0]) && (((key ^ mem_d[i]) & mem_m[i]) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) begin
        hit     = 1'b1;
        hit_idx = AW'(i);
      end
    end
  end

  always_comb begin
    ctrl_v          = '0;
    ctrl_v[0]       = start_q;
    ctrl_v[3:1]     = op_q;
    ctrl_v[14:10]   = ram_q;
    ctrl_v[15]      = clr_q;
    ctrl_v[16 +: AW] = addr_q;
    ctrl_v[27]      = found_q;
  end

  always_comb begin
    if (ctrl_sel)
      bus_rdata = ctrl_v;
    else if (int'(bus_addr) < WORDS)
      bus_rdata = stage_d[int'(bus_addr)*32 +: 32];
    else if (int'(bus_addr) < CTRL_A)
      bus_rdata = stage_m[(int'(bus_addr) - WORDS)*32 +: 32];
    else
      bus_rdata = '0;
  end
endmodule

module tcam_table_chk #(
  parameter int WORDS = 8,
  parameter int AW    = 8,
  parameter int BA_W  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_q,
  input logic            clr_q,
  input logic            found_q,
  input logic [2:0]      op_q,
  input logic [4:0]      ram_q,
  input logic [AW-1:0]   addr_q,
  input logic            bus_re,
  input logic [BA_W-1:0] bus_addr,
  input logic            hit,
  input logic [1:0]      ext_ram_go
);
  assert_rw_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !clr_q && op_q != 3'd4) |=> !start_q);

  assert_search_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && op_q == 3'd4 && ram_q == 5'd1 && !found_q)
      |=> (found_q && $stable(addr_q)) || !start_q || addr_q == AW'($past(addr_q) + 1'b1));

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !(bus_re && int'(bus_addr) == WORDS - 1)) |=> (found_q && $stable(addr_q)));

  assert_wipe_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_q) |-> !hit);

  assert_busy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !start_q);

  assert_ext_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_ram_go));

  assert_ext_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ram_go != 2'b00) |=> (ext_ram_go == 2'b00));
endmodule

bind tcam_table tcam_table_chk #(.WORDS(WORDS), .AW(AW), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_q(start_q), .clr_q(clr_q), .found_q(found_q),
  .op_q(op_q), .ram_q(ram_q), .addr_q(addr_q), .bus_re(bus_re), .bus_addr(bus_addr),
  .hit(hit), .ext_ram_go(ext_ram_go)
);

// File: tb/sim_tcam_table.sv
module sim_tcam_table;
  localparam int ENTRIES = 16;
  localparam int WORDS   = 8;
  localparam int AW      = 4;
  localparam int KEY_W   = 256;
  localparam int BA_W    = 5;
  localparam int CTRL    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [BA_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [KEY_W-1:0] key = '0;
  logic hit;
  logic [AW-1:0] hit_idx;
  logic [1:0] ext_ram_go;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tcam_table #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key(key), .hit(hit),
    .hit_idx(hit_idx), .ext_ram_go(ext_ram_go)
  );

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int op, input int ram, input int addr,
                                     input bit go, input bit wipe);
    return (32'(addr) << 16) | (32'(wipe) << 15) | (32'(ram) << 10) | (32'(op) << 1) | 32'(go);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = BA_W'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_re = 1'b1; bus_addr = BA_W'(a);
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic put_stage(input logic [KEY_W-1:0] d, input logic [KEY_W-1:0] m);
    for (int w = 0; w < WORDS; w++) begin
      wr(w, d[w*32 +: 32]);
      wr(WORDS + w, m[w*32 +: 32]);
    end
  endtask

  task automatic tcam_op(input int op, input int addr);
    logic [31:0] v;
    wr(CTRL, mk(op, 1, addr, 1'b1, 1'b0));
    rd(CTRL, v);
    v = v;
  endtask

  task automatic look(input string r, input logic [KEY_W-1:0] k, input bit eh, input int ei);
    key = k;
    #1;
    check(r, {31'd0, hit}, {31'd0, eh});
    if (eh) check(r, {28'd0, hit_idx}, 32'(ei));
  endtask

  logic [KEY_W-1:0] kA, kB;

  task automatic t_reset;
    logic [31:0] v;
    rd(CTRL, v); check("R1 ctrl", v, 0);
    rd(3, v); check("R1 stage", v, 0);
    look("R1 nohit", {KEY_W{1'b1}}, 1'b0, 0);
  endtask

  task automatic t_stage;
    logic [31:0] v;
    wr(2, 32'hA5A5_1234);
    wr(WORDS + 5, 32'h0F0F_7788);
    rd(2, v); check("R2 data", v, 32'hA5A5_1234);
    rd(WORDS + 5, v); check("R2 mask", v, 32'h0F0F_7788);
  endtask

  task automatic t_write;
    logic [KEY_W-1:0] d, m;
    logic [31:0] v;
    d = '0; m = '0;
    d[31:0] = 32'hBEEF_0001; d[63:32] = 32'hCAFE_0000;
    m[31:0] = 32'hFFFF_0000; m[63:32] = 32'hFFFF_0000;
    put_stage(d, m);
    wr(CTRL, mk(2, 1, 3, 1'b1, 1'b0));
    rd(CTRL, v); check("R3 start busy", v & 1, 1);
    rd(CTRL, v); check("R3 start done", v & 1, 0);
    kA = {KEY_W{1'b1}}; kA[31:0] = 32'hBEEF_1234; kA[63:32] = 32'hCAFE_FFFF;
    look("R5 match", kA, 1'b1, 3);
    kB = kA; kB[16] = 1'b0;
    look("R5 miss", kB, 1'b0, 0);
  endtask

  task automatic t_prio;
    logic [KEY_W-1:0] d;
    d = '0; d[31:0] = 32'h0000_0002;
    put_stage(d, '0);
    tcam_op(2, 7);
    look("R6 lowest", kA, 1'b1, 3);
    look("R6 wild", kB, 1'b1, 7);
    tcam_op(2, 1);
    look("R6 wild low", kA, 1'b1, 1);
  endtask

  task automatic t_read;
    logic [31:0] v;
    put_stage('0, '0);
    tcam_op(1, 3);
    rd(0, v); check("R4 data0", v, 32'hBEEF_0001);
    rd(1, v); check("R4 data1", v, 32'hCAFE_0000);
    rd(WORDS + 1, v); check("R4 mask1", v, 32'hFFFF_0000);
  endtask

  task automatic t_delete;
    logic [31:0] v;
    tcam_op(1, 1);
    rd(0, v); check("R7 readback", v, 32'h0000_0002);
    wr(0, v & ~32'h3);
    tcam_op(2, 1);
    look("R7 gone", kA, 1'b1, 3);
    look("R7 gone wild", kB, 1'b1, 7);
  endtask

  task automatic poll(input logic [31:0] msk, input logic [31:0] val, output logic [31:0] v);
    for (int i = 0; i < 60; i++) begin
      rd(CTRL, v);
      if ((v & msk) == val) return;
    end
  endtask

  task automatic t_search;
    logic [31:0] v;
    wr(CTRL, mk(4, 1, 4, 1'b1, 1'b0));
    poll(32'h0800_0000, 32'h0800_0000, v);
    check("R8 flag", (v >> 27) & 1, 1);
    check("R8 addr", (v >> 16) & 32'hFF, 7);
    rd(CTRL, v);
    check("R9 held", (v >> 16) & 32'hFF, 7);
    check("R9 held flag", (v >> 27) & 1, 1);
    rd(0, v); check("R8 stage", v, 32'h0000_0002);
    rd(WORDS - 1, v);
    poll(32'h1, 32'h0, v);
    check("R9 done", v & 1, 0);
    check("R9 noflag", (v >> 27) & 1, 0);
    check("R9 last", (v >> 16) & 32'hFF, ENTRIES - 1);
  endtask

  task automatic t_ext;
    logic [31:0] v;
    wr(CTRL, mk(2, 2, 0, 1'b1, 1'b0));
    check("R12 act go", {30'd0, ext_ram_go}, 1);
    @(negedge clk);
    check("R12 act end", {30'd0, ext_ram_go}, 0);
    rd(CTRL, v); check("R12 start clr", v & 1, 0);
    wr(CTRL, mk(1, 4, 0, 1'b1, 1'b0));
    check("R12 meter go", {30'd0, ext_ram_go}, 2);
    @(negedge clk);
    check("R12 meter end", {30'd0, ext_ram_go}, 0);
    look("R12 untouched", kB, 1'b1, 7);
  endtask

  task automatic t_wipe;
    logic [31:0] v;
    wr(CTRL, mk(0, 1, 0, 1'b0, 1'b1));
    wr(CTRL, mk(2, 1, 0, 1'b1, 1'b0));
    rd(CTRL, v); check("R10 busy", (v >> 15) & 1, 1);
    poll(32'h8000, 32'h0, v);
    check("R10 done", (v >> 15) & 1, 0);
    check("R11 ignored op", (v >> 1) & 7, 0);
    check("R11 no start", v & 1, 0);
    look("R10 empty", kA, 1'b0, 0);
    look("R10 empty wild", kB, 1'b0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_write();
    t_prio();
    t_read();
    t_delete();
    t_search();
    t_ext();
    t_wipe();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule